// File: doc/BRIEF.md
# Carry-Chain Modifier Shadow Register

This block lives in an instruction decode stage. A carry-chain prefix instruction holds a 16-bit immediate, and the block spreads that immediate over the eight instructions that come after the prefix. When the prefix decodes, the immediate is loaded into a shadow shift register and a slot counter is set to eight. Each time a later instruction advances through decode, the block presents that instruction's 2-bit carry attribute and then moves to the next slot. The attribute says whether the instruction consumes the running carry, produces it, does both, or does not touch it.

The prefix also names the register that carries the 64-bit carry value from one chained instruction to the next. The block holds that register index for the whole window. A window can be interrupted part-way through. For that case the block exposes its remaining shadow bits, slot count and accumulator index on a save port, and it takes them back on a restore port. A pipeline flush clears the window. A restore in the same cycle as a flush takes priority over the flush.

Top module: `carry_shadow_reg`

## Requirements
- R1: After reset, `win_active` is 0, `slot_attr` is 00 and `save_count` is 0.
- R2: One cycle after `pfx_valid` is sampled high (with no restore), `win_active` is 1, `save_count` is 8, `save_bits` equals `pfx_imm`, and `acc_index` equals `pfx_acc`.
- R3: While the window is active, `slot_attr` equals bits [1:0] of the remaining shadow. Slot k of the window receives immediate bits [2k+1:2k], starting with slot 0. Each `inst_adv` sampled high with the window active and no prefix, flush or restore shifts the shadow right by 2, filling with zeros, and lowers `save_count` by one.
- R4: The eighth advance ends the window: `win_active` drops to 0 and `slot_attr` reads 00. The attribute codes are 00 no carry involvement, 01 carry-in only, 10 carry-out only, 11 carry-in and carry-out.
- R5: A prefix that decodes while a window is active replaces the remaining shadow, resets the count to 8 and replaces the accumulator index.
- R6: `flush` sampled high without `rst_valid` clears the shadow and the count, so the window ends on the next cycle.
- R7: `rst_valid` takes priority over `flush`, over `pfx_valid` and over `inst_adv` in the same cycle. It loads `rst_bits`, `rst_count` and `rst_acc`.
- R8: `save_bits`, `save_count` and `save_acc` always show the current remaining window. Restoring those values resumes the window with the same attribute sequence.
- R9: A restored count above 8 is clamped to 8.
- R10: `inst_adv` has no effect when no window is active. It also has no effect in the same cycle as a prefix: the first slot goes to the instruction after the prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pfx_valid | input | 1 | Carry-chain prefix decoded this cycle |
| pfx_imm | input | 16 | Prefix immediate holding eight 2-bit attributes |
| pfx_acc | input | 6 | Carry accumulator register index named by the prefix |
| inst_adv | input | 1 | A following instruction advances out of decode |
| flush | input | 1 | Pipeline flush |
| rst_valid | input | 1 | Restore the saved window state |
| rst_bits | input | 16 | Shadow bits to restore |
| rst_count | input | 4 | Remaining slot count to restore |
| rst_acc | input | 6 | Accumulator index to restore |
| slot_attr | output | 2 | Attribute for the instruction in decode |
| acc_index | output | 6 | Carry accumulator register index |
| win_active | output | 1 | A window is in progress |
| save_bits | output | 16 | Remaining shadow bits, for saving |
| save_count | output | 4 | Remaining slot count, for saving |
| save_acc | output | 6 | Accumulator index, for saving |

## Verification
The hardest case to reach is an interrupt in the middle of a window: a partly consumed window has to be flushed and then resumed with the attribute sequence unchanged. The bench loads a prefix and advances twice. It captures the save port, flushes, and confirms the window is idle. It then drives the captured values back through the restore port and walks the remaining six slots against the attributes worked out from the original immediate. Separate scenarios cover a restore that coincides with a flush and with a new prefix, and a restored count that is out of range.

// File: rtl/carry_shadow_pkg.sv
// Package: shared parameters and types for the carry-chain shadow register.
// Assumes every user agrees on the attribute width and the window length.
package carry_shadow_pkg;

    localparam int ATTR_W = 2;

    // Carry attribute codes handed to each chained instruction
    typedef enum logic [ATTR_W-1:0] {
        CA_NONE  = 2'b00,
        CA_CIN   = 2'b01,
        CA_COUT  = 2'b10,
        CA_BOTH  = 2'b11
    } carry_attr_e;

    // Window operation picked once per cycle, in priority order
    typedef enum logic [2:0] {
        WOP_HOLD    = 3'd0,
        WOP_RESTORE = 3'd1,
        WOP_FLUSH   = 3'd2,
        WOP_LOAD    = 3'd3,
        WOP_SHIFT   = 3'd4
    } win_op_e;

endpackage

// File: rtl/cs_op_select.sv
// Module: cs_op_select
// Picks the single window operation for this cycle. The priority is
// restore, then flush, then prefix load, then shift on an advance.
// Assumes the inputs are already qualified decode signals.
module cs_op_select
    import carry_shadow_pkg::*;
(
    input  logic    restore_req,
    input  logic    flush_req,
    input  logic    load_req,
    input  logic    adv_req,
    input  logic    win_busy,
    output win_op_e op
);

    // Priority encode the requests into one operation
    always_comb begin
        if (restore_req)            op = WOP_RESTORE;
        else if (flush_req)         op = WOP_FLUSH;
        else if (load_req)          op = WOP_LOAD;
        else if (adv_req && win_busy) op = WOP_SHIFT;
        else                        op = WOP_HOLD;
    end

endmodule

// File: rtl/cs_shadow_shift.sv
// Module: cs_shadow_shift
// Holds the remaining attribute bits of the window. A load copies the
// immediate, a restore copies the saved bits, a flush zeroes the register,
// and a shift drops the lowest attribute and fills the top with zeros.
// Assumes op is one-hot in meaning (one operation per cycle).
module cs_shadow_shift
    import carry_shadow_pkg::*;
#(
    parameter int SLOTS = 8,
    localparam int BITS_W = SLOTS * ATTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  win_op_e           op,
    input  logic [BITS_W-1:0] load_bits,
    input  logic [BITS_W-1:0] restore_bits,
    output logic [BITS_W-1:0] bits_q
);

    // Update the shadow register according to the selected operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            case (op)
                WOP_RESTORE: bits_q <= restore_bits;
                WOP_FLUSH:   bits_q <= '0;
                WOP_LOAD:    bits_q <= load_bits;
                WOP_SHIFT:   bits_q <= bits_q >> ATTR_W;
                default:     bits_q <= bits_q;
            endcase
        end
    end

    // R3: a shift drops exactly one attribute from the bottom
    a_r3_shift_by_attr: assert property (@(posedge clk) disable iff (!rst_n)
        (op == WOP_SHIFT) |=> (bits_q == ($past(bits_q) >> ATTR_W)));

    // R6: a flush leaves no attribute behind
    a_r6_flush_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (op == WOP_FLUSH) |=> (bits_q == '0));

endmodule

// File: rtl/cs_window_count.sv
// Module: cs_window_count
// Counts the slots left in the window. A load sets it to SLOTS, a shift
// lowers it by one, a flush clears it, and a restore takes the saved value
// clamped to SLOTS. Assumes a shift is requested only while the count is
// non-zero.
module cs_window_count
    import carry_shadow_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  win_op_e          op,
    input  logic [CNT_W-1:0] restore_cnt,
    output logic [CNT_W-1:0] cnt_q,
    output logic             busy
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(SLOTS);

    logic [CNT_W-1:0] restore_clamped;

    // Clamp a restored count to the window length
    always_comb begin
        restore_clamped = (restore_cnt > FULL) ? FULL : restore_cnt;
    end

    // Update the slot counter according to the selected operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            case (op)
                WOP_RESTORE: cnt_q <= restore_clamped;
                WOP_FLUSH:   cnt_q <= '0;
                WOP_LOAD:    cnt_q <= FULL;
                WOP_SHIFT:   cnt_q <= cnt_q - 1'b1;
                default:     cnt_q <= cnt_q;
            endcase
        end
    end

    // Flag a window in progress
    always_comb begin
        busy = (cnt_q != '0);
    end

    // R9: the count never goes past the window length
    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);

    // R2: a prefix load fills the window
    a_r2_load_full: assert property (@(posedge clk) disable iff (!rst_n)
        (op == WOP_LOAD) |=> (cnt_q == FULL));

    // R3: a shift consumes exactly one slot
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (op == WOP_SHIFT) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/carry_shadow_reg.sv
// Module: carry_shadow_reg (top)
// Decode-stage shadow for a carry-chain prefix. It hands one 2-bit carry
// attribute to each of the SLOTS instructions that follow the prefix, holds
// the carry accumulator register index, and exposes save/restore ports so
// an interrupted window can resume. Assumes inst_adv pulses once per
// instruction leaving decode, and that the prefix itself is not counted.
module carry_shadow_reg
    import carry_shadow_pkg::*;
#(
    parameter int SLOTS     = 8,
    parameter int REG_IDX_W = 6,
    localparam int BITS_W   = SLOTS * ATTR_W,
    localparam int CNT_W    = $clog2(SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pfx_valid,
    input  logic [BITS_W-1:0]    pfx_imm,
    input  logic [REG_IDX_W-1:0] pfx_acc,
    input  logic                 inst_adv,
    input  logic                 flush,
    input  logic                 rst_valid,
    input  logic [BITS_W-1:0]    rst_bits,
    input  logic [CNT_W-1:0]     rst_count,
    input  logic [REG_IDX_W-1:0] rst_acc,
    output logic [ATTR_W-1:0]    slot_attr,
    output logic [REG_IDX_W-1:0] acc_index,
    output logic                 win_active,
    output logic [BITS_W-1:0]    save_bits,
    output logic [CNT_W-1:0]     save_count,
    output logic [REG_IDX_W-1:0] save_acc
);

    win_op_e              op;
    logic [BITS_W-1:0]    bits_q;
    logic [CNT_W-1:0]     cnt_q;
    logic                 busy;
    logic [REG_IDX_W-1:0] acc_q;

    cs_op_select u_sel (
        .restore_req (rst_valid),
        .flush_req   (flush),
        .load_req    (pfx_valid),
        .adv_req     (inst_adv),
        .win_busy    (busy),
        .op          (op)
    );

    cs_shadow_shift #(.SLOTS(SLOTS)) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .op           (op),
        .load_bits    (pfx_imm),
        .restore_bits (rst_bits),
        .bits_q       (bits_q)
    );

    cs_window_count #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .restore_cnt (rst_count),
        .cnt_q       (cnt_q),
        .busy        (busy)
    );

    // Keep the carry accumulator register index for the window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (op == WOP_RESTORE) begin
            acc_q <= rst_acc;
        end else if (op == WOP_LOAD) begin
            acc_q <= pfx_acc;
        end
    end

    // Drive the attribute and the save port from the window state
    always_comb begin
        win_active = busy;
        slot_attr  = busy ? bits_q[ATTR_W-1:0] : ATTR_W'(CA_NONE);
        acc_index  = acc_q;
        save_bits  = bits_q;
        save_count = cnt_q;
        save_acc   = acc_q;
    end

    // R10: an advance with no window and no other request changes nothing
    a_r10_idle_adv: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_active && inst_adv && !pfx_valid && !flush && !rst_valid)
        |=> (!win_active && $stable(save_bits)));

    // R7: a restore wins over a flush in the same cycle
    a_r7_restore_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_valid && flush) |=> (save_bits == $past(rst_bits)));

    // R4: an idle window hands out no carry involvement
    a_r4_idle_none: assert property (@(posedge clk) disable iff (!rst_n)
        (save_count == '0) |-> (slot_attr == 2'b00));

endmodule

// File: tb/carry_shadow_reg_test.sv
module carry_shadow_reg_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pfx_valid, inst_adv, flush, rst_valid;
    logic [15:0] pfx_imm, rst_bits;
    logic [5:0]  pfx_acc, rst_acc;
    logic [3:0]  rst_count;
    logic [1:0]  slot_attr;
    logic [5:0]  acc_index, save_acc;
    logic        win_active;
    logic [15:0] save_bits;
    logic [3:0]  save_count;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    carry_shadow_reg uut (
        .clk(clk), .rst_n(rst_n), .pfx_valid(pfx_valid), .pfx_imm(pfx_imm),
        .pfx_acc(pfx_acc), .inst_adv(inst_adv), .flush(flush),
        .rst_valid(rst_valid), .rst_bits(rst_bits), .rst_count(rst_count),
        .rst_acc(rst_acc), .slot_attr(slot_attr), .acc_index(acc_index),
        .win_active(win_active), .save_bits(save_bits),
        .save_count(save_count), .save_acc(save_acc)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply the current inputs for one clock edge, then return inputs to idle
    task automatic tick();
        @(posedge clk);
        #1;
        pfx_valid = 0; inst_adv = 0; flush = 0; rst_valid = 0;
    endtask

    function automatic logic [1:0] slot_of(logic [15:0] imm, int k);
        return imm[2*k +: 2];
    endfunction

    task automatic t_reset();
        rst_n = 0; pfx_valid = 0; inst_adv = 0; flush = 0; rst_valid = 0;
        pfx_imm = 0; pfx_acc = 0; rst_bits = 0; rst_count = 0; rst_acc = 0;
        tick(); tick();
        rst_n = 1;
        tick();
        chk("R1 active", win_active, 0);
        chk("R1 attr", slot_attr, 0);
        chk("R1 count", save_count, 0);
    endtask

    task automatic t_full_window();
        logic [15:0] imm = 16'hE4E4;
        pfx_valid = 1; pfx_imm = imm; pfx_acc = 6'd17; inst_adv = 1;
        tick();
        chk("R2 active", win_active, 1);
        chk("R2 count", save_count, 8);
        chk("R2 bits", save_bits, imm);
        chk("R2 acc", acc_index, 17);
        chk("R10 adv with prefix not consumed", slot_attr, slot_of(imm, 0));
        for (int k = 0; k < 8; k++) begin
            chk("R3 attr", slot_attr, slot_of(imm, k));
            chk("R3 count", save_count, 8 - k);
            inst_adv = 1;
            tick();
        end
        chk("R4 window ends", win_active, 0);
        chk("R4 attr none", slot_attr, 0);
        inst_adv = 1;
        tick();
        chk("R10 idle adv count", save_count, 0);
        chk("R10 idle adv bits", save_bits, 0);
    endtask

    task automatic t_hold_and_replace();
        pfx_valid = 1; pfx_imm = 16'h1B1B; pfx_acc = 6'd3;
        tick();
        tick(); tick();
        chk("R3 no adv hold", slot_attr, 2'b11);
        chk("R3 no adv count", save_count, 8);
        for (int k = 0; k < 3; k++) begin inst_adv = 1; tick(); end
        chk("R3 after three", slot_attr, 2'b00);
        pfx_valid = 1; pfx_imm = 16'h0002; pfx_acc = 6'd9;
        tick();
        chk("R5 count", save_count, 8);
        chk("R5 attr", slot_attr, 2'b10);
        chk("R5 acc", acc_index, 9);
        chk("R5 bits", save_bits, 16'h0002);
    endtask

    task automatic t_flush();
        flush = 1; inst_adv = 1;
        tick();
        chk("R6 inactive", win_active, 0);
        chk("R6 bits", save_bits, 0);
        chk("R6 attr", slot_attr, 0);
    endtask

    task automatic t_interrupt_resume();
        logic [15:0] imm = 16'h6C93;
        logic [15:0] sb; logic [3:0] sc; logic [5:0] sa;
        pfx_valid = 1; pfx_imm = imm; pfx_acc = 6'd42;
        tick();
        inst_adv = 1; tick();
        inst_adv = 1; tick();
        sb = save_bits; sc = save_count; sa = save_acc;
        chk("R8 save bits", sb, imm >> 4);
        chk("R8 save count", sc, 6);
        chk("R8 save acc", sa, 42);
        flush = 1;
        tick();
        chk("R6 flushed", win_active, 0);
        rst_valid = 1; rst_bits = sb; rst_count = sc; rst_acc = sa;
        flush = 1; pfx_valid = 1; pfx_imm = 16'hFFFF; pfx_acc = 6'd1; inst_adv = 1;
        tick();
        chk("R7 restore over flush/prefix count", save_count, 6);
        chk("R7 acc", acc_index, 42);
        for (int k = 2; k < 8; k++) begin
            chk("R8 resumed attr", slot_attr, slot_of(imm, k));
            inst_adv = 1;
            tick();
        end
        chk("R8 resumed end", win_active, 0);
    endtask

    task automatic t_clamp();
        rst_valid = 1; rst_bits = 16'hAAAA; rst_count = 4'd13; rst_acc = 6'd5;
        tick();
        chk("R9 clamp", save_count, 8);
        chk("R9 active", win_active, 1);
        chk("R9 attr", slot_attr, 2'b10);
        flush = 1; tick();
    endtask

    initial begin
        t_reset();
        t_full_window();
        t_hold_and_replace();
        t_flush();
        t_interrupt_resume();
        t_clamp();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule